// File: doc/BRIEF.md
# Daisy-Chain Depth Expansion Token Controller

This block is the per-device control that lets several identical FIFO instances behave as one deeper FIFO. The instances form a ring: the expansion output of each one drives the expansion input of the next. Two tokens travel around the ring. The write token marks the instance that currently accepts writes, and the read token marks the instance that currently supplies reads. The instance that holds a token commits the matching local strobe. When a strobe lands on its last physical location, the instance gives the token away.

Both kinds of hand-off travel on the same single expansion line as one-cycle pulses. For each instance, the hand-offs it sends always alternate between write and read, and the first one after reset is a write. A receiver therefore knows what each arriving pulse carries by toggling a one-bit expectation. After reset, the instance whose head-select input is high owns both tokens, and every other instance owns neither.

Storage, pointers and the chain-wide full and empty flags are outside this block. The grant outputs drive the local memory enables. The owner outputs let system logic combine per-device flags.

Top module: `daisy_token_ctrl`

## Requirements
- R1: While `rst` is high, both `wr_owner` and `rd_owner` take the value of `head_sel`. `xout` is 0 during reset and in the first cycle after it.
- R2: `wr_grant` is high in the same cycle as `wr_stb` exactly when the instance holds the write token. `rd_grant` behaves the same way for `rd_stb` and the read token. A strobe given without the token is a no-op: no grant, no pulse and no change of ownership.
- R3: A granted write with `wr_last` high releases the write token at the next clock edge, and `xout` is high in the following cycle.
- R4: A granted read with `rd_last` high releases the read token at the next clock edge, and `xout` is high in the following cycle.
- R5: A token is kept unless it is released under R3 or R4. In particular, a `wr_last` or `rd_last` with no matching grant has no effect.
- R6: Pulses arriving on `xin` are decoded in alternation. The first one after reset hands over the write token, the next one the read token, and so on. The token is owned from the clock edge that samples the pulse.
- R7: If a write hand-off and a read hand-off happen in the same cycle, `xout` is high for two consecutive cycles. The write hand-off comes first.
- R8: `xout` is low in every cycle that is not the result of a hand-off under R3, R4 or R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| head_sel | input | 1 | High on the instance that starts owning both tokens |
| xin | input | 1 | Hand-off pulse from the previous instance |
| wr_stb | input | 1 | Local write request |
| rd_stb | input | 1 | Local read request |
| wr_last | input | 1 | Write pointer is at the last physical location |
| rd_last | input | 1 | Read pointer is at the last physical location |
| wr_grant | output | 1 | Write is committed this cycle |
| rd_grant | output | 1 | Read is committed this cycle |
| wr_owner | output | 1 | Instance holds the write token |
| rd_owner | output | 1 | Instance holds the read token |
| xout | output | 1 | Hand-off pulse to the next instance |

## Verification
The grants are combinational, so they are due in the same cycle as the strobe. The bench reads them 1 ns after it drives the inputs at the falling edge. A hand-off pulse on `xout` is due exactly one rising edge after the granted last-location operation, and under R7 the read pulse comes one edge after that. For each cycle the driver queues the expected `xout` value, and the monitor pops and compares it 2 ns after the rising edge. Ownership changes become visible after the edge that samples a hand-off. They are compared at every falling edge against a token model that the bench keeps from the requirements.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int NUM_HOPS = 2;

    typedef enum logic {
        HOP_WR = 1'b0,
        HOP_RD = 1'b1
    } hop_kind_t;

    typedef struct packed {
        logic pulse;
        logic owe_rd;
    } hop_state_t;

    function automatic hop_kind_t next_kind(hop_kind_t k);
        return (k == HOP_WR) ? HOP_RD : HOP_WR;
    endfunction

endpackage

// File: rtl/dtc_arrival.sv
module dtc_arrival
    import dtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                xin,
    output logic [NUM_HOPS-1:0] take
);

    hop_kind_t expect_q;

    always_ff @(posedge clk) begin
        if (rst)
            expect_q <= HOP_WR;
        else if (xin)
            expect_q <= next_kind(expect_q);
    end

    always_comb begin
        take = '0;
        take[int'(expect_q)] = xin;
    end

endmodule

// File: rtl/dtc_token.sv
module dtc_token (
    input  logic clk,
    input  logic rst,
    input  logic head,
    input  logic stb,
    input  logic last,
    input  logic take,
    output logic grant,
    output logic owner,
    output logic give
);

    logic owner_q;

    assign grant = stb & owner_q;
    assign give  = grant & last;
    assign owner = owner_q;

    always_ff @(posedge clk) begin
        if (rst)
            owner_q <= head;
        else if (take)
            owner_q <= 1'b1;
        else if (give)
            owner_q <= 1'b0;
    end

endmodule

// File: rtl/dtc_launcher.sv
module dtc_launcher
    import dtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_HOPS-1:0] give,
    output logic                xout
);

    hop_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.pulse  <= (|give) | st_q.owe_rd;
            st_q.owe_rd <= give[int'(HOP_WR)] & give[int'(HOP_RD)];
        end
    end

    assign xout = st_q.pulse;

endmodule

// File: rtl/daisy_token_ctrl.sv
module daisy_token_ctrl
    import dtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic head_sel,
    input  logic xin,
    input  logic wr_stb,
    input  logic rd_stb,
    input  logic wr_last,
    input  logic rd_last,
    output logic wr_grant,
    output logic rd_grant,
    output logic wr_owner,
    output logic rd_owner,
    output logic xout
);

    logic [NUM_HOPS-1:0] stb_v;
    logic [NUM_HOPS-1:0] last_v;
    logic [NUM_HOPS-1:0] take_v;
    logic [NUM_HOPS-1:0] grant_v;
    logic [NUM_HOPS-1:0] owner_v;
    logic [NUM_HOPS-1:0] give_v;

    assign stb_v[int'(HOP_WR)]  = wr_stb;
    assign stb_v[int'(HOP_RD)]  = rd_stb;
    assign last_v[int'(HOP_WR)] = wr_last;
    assign last_v[int'(HOP_RD)] = rd_last;

    dtc_arrival u_arrival (
        .clk  (clk),
        .rst  (rst),
        .xin  (xin),
        .take (take_v)
    );

    for (genvar k = 0; k < NUM_HOPS; k++) begin : g_tok
        dtc_token u_token (
            .clk   (clk),
            .rst   (rst),
            .head  (head_sel),
            .stb   (stb_v[k]),
            .last  (last_v[k]),
            .take  (take_v[k]),
            .grant (grant_v[k]),
            .owner (owner_v[k]),
            .give  (give_v[k])
        );
    end

    dtc_launcher u_launcher (
        .clk  (clk),
        .rst  (rst),
        .give (give_v),
        .xout (xout)
    );

    assign wr_grant = grant_v[int'(HOP_WR)];
    assign rd_grant = grant_v[int'(HOP_RD)];
    assign wr_owner = owner_v[int'(HOP_WR)];
    assign rd_owner = owner_v[int'(HOP_RD)];

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker (
    input logic clk,
    input logic rst,
    input logic xin,
    input logic wr_last,
    input logic rd_last,
    input logic wr_grant,
    input logic rd_grant,
    input logic wr_owner,
    input logic rd_owner,
    input logic xout
);

    a_r3_wr_handoff: assert property (@(posedge clk) disable iff (rst)
        (wr_grant && wr_last) |=> (xout && !wr_owner));

    a_r4_rd_handoff: assert property (@(posedge clk) disable iff (rst)
        (rd_grant && rd_last) |=> (xout && !rd_owner));

    a_r5_wr_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_owner && !(wr_grant && wr_last)) |=> wr_owner);

    a_r5_rd_kept: assert property (@(posedge clk) disable iff (rst)
        (rd_owner && !(rd_grant && rd_last)) |=> rd_owner);

    a_r6_wr_gain: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_owner) |-> $past(xin));

    a_r6_rd_gain: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_owner) |-> $past(xin));

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (xout && !$past(wr_grant && wr_last) && !$past(rd_grant && rd_last))
        |-> $past(xout));

endmodule

bind daisy_token_ctrl dtc_checker u_dtc_checker (
    .clk      (clk),
    .rst      (rst),
    .xin      (xin),
    .wr_last  (wr_last),
    .rd_last  (rd_last),
    .wr_grant (wr_grant),
    .rd_grant (rd_grant),
    .wr_owner (wr_owner),
    .rd_owner (rd_owner),
    .xout     (xout)
);

// File: tb/test_daisy_token_ctrl.sv
module test_daisy_token_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic head_sel = 1'b1;
    logic xin = 1'b0;
    logic wr_stb = 1'b0;
    logic rd_stb = 1'b0;
    logic wr_last = 1'b0;
    logic rd_last = 1'b0;
    logic wr_grant, rd_grant, wr_owner, rd_owner, xout;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    logic m_w, m_r, m_expect_rd, m_owe;
    logic exp_q[$];

    always #4 clk = ~clk;

    daisy_token_ctrl i_daisy_token_ctrl (
        .clk(clk), .rst(rst), .head_sel(head_sel), .xin(xin),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_last(wr_last), .rd_last(rd_last),
        .wr_grant(wr_grant), .rd_grant(rd_grant),
        .wr_owner(wr_owner), .rd_owner(rd_owner), .xout(xout)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // monitor: compares xout after each rising edge with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic e;
                e = exp_q.pop_front();
                chk(e ? cur_req : "R8", "xout", xout, e);
            end
        end
    end

    task automatic do_reset(input logic head);
        @(negedge clk);
        rst = 1'b1;
        head_sel = head;
        {xin, wr_stb, rd_stb, wr_last, rd_last} = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "wr_owner in reset", wr_owner, head);
        chk("R1", "rd_owner in reset", rd_owner, head);
        chk("R1", "xout in reset", xout, 1'b0);
        exp_q.delete();
        m_w = head;
        m_r = head;
        m_expect_rd = 1'b0;
        m_owe = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // driver: one cycle of stimulus, checks same-cycle outputs, queues xout
    task automatic step(input logic w, input logic r, input logic wl,
                        input logic rl, input logic x);
        logic eg_w, eg_r, give_w, give_r, take_w, take_r;
        @(negedge clk);
        wr_stb = w; rd_stb = r; wr_last = wl; rd_last = rl; xin = x;
        #1;
        eg_w = w & m_w;
        eg_r = r & m_r;
        chk(cur_req, "wr_owner", wr_owner, m_w);
        chk(cur_req, "rd_owner", rd_owner, m_r);
        chk(cur_req, "wr_grant", wr_grant, eg_w);
        chk(cur_req, "rd_grant", rd_grant, eg_r);
        give_w = eg_w & wl;
        give_r = eg_r & rl;
        exp_q.push_back(give_w | give_r | m_owe);
        m_owe = give_w & give_r;
        take_w = x & ~m_expect_rd;
        take_r = x & m_expect_rd;
        if (x) m_expect_rd = ~m_expect_rd;
        m_w = take_w ? 1'b1 : (give_w ? 1'b0 : m_w);
        m_r = take_r ? 1'b1 : (give_r ? 1'b0 : m_r);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        // R1: head instance starts with both tokens
        do_reset(1'b1);
        #1;
        chk("R1", "xout after reset", xout, 1'b0);

        // R2: strobes with tokens are granted
        cur_req = "R2";
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);

        // R5: last flags without strobes change nothing
        cur_req = "R5";
        step(0, 0, 1, 1, 0);
        step(0, 1, 1, 0, 0);
        step(1, 0, 0, 1, 0);
        idle(2);

        // R3: write at last location hands the write token on
        cur_req = "R3";
        step(1, 0, 1, 0, 0);
        idle(2);
        // R2: write strobe without token is a no-op
        cur_req = "R2";
        step(1, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        idle(1);

        // R4: read at last location hands the read token on
        cur_req = "R4";
        step(0, 1, 0, 1, 0);
        idle(2);
        cur_req = "R2";
        step(0, 1, 0, 1, 0);

        // R6: arrivals alternate write then read
        cur_req = "R6";
        step(0, 0, 0, 0, 1);
        step(1, 1, 0, 0, 0);
        idle(1);
        step(0, 0, 0, 0, 1);
        step(1, 1, 0, 0, 0);
        idle(1);

        // R7: both hand-offs in one cycle give two pulses, write first
        cur_req = "R7";
        step(1, 1, 1, 1, 0);
        idle(3);
        // R6: the next arrival after the pair is again a write hand-off
        cur_req = "R6";
        step(0, 0, 0, 0, 1);
        idle(1);
        step(0, 0, 0, 0, 1);
        idle(1);

        // R1: non-head instance starts with no token
        do_reset(1'b0);
        cur_req = "R2";
        step(1, 1, 1, 1, 0);
        idle(1);
        cur_req = "R6";
        step(0, 0, 0, 0, 1);
        step(1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(1, 1, 0, 0, 0);
        // R3 and R4 in separate cycles on a non-head instance
        cur_req = "R3";
        step(1, 0, 1, 0, 0);
        idle(1);
        cur_req = "R4";
        step(0, 1, 0, 1, 0);
        cur_req = "R8";
        idle(4);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule